// File: doc/BRIEF.md
# Framebuffer Control Register Interface

This block is the register file of a palette-based display controller. A host reaches it through a simple valid/ready bus that carries 32-bit word-aligned reads and writes. The block holds four kinds of state. The first is a 256-entry colour lookup table, exposed to the scanout logic through a combinational lookup port. The second is a three-entry cursor colour table and the third is a 512-word cursor bitmap, both readable by the host. The fourth is a set of scalar registers: control, screen base, cursor location, horizontal and vertical size.

Colours travel on the bus as packed 24-bit RGB values. Size values are rescaled between their bus form and their stored form. The control word is decoded into a pixel depth, a blanking flag and a cursor-disable flag. Writes to the video timing registers are accepted and have no effect. A dedicated reset address clears all state. The block also owns the frame interrupt line: a pulse from the scanout engine raises it, and any host write lowers it.

Top module: `fb_ctrl_regs`

## Requirements
- R1: A write anywhere in the byte window 0x800..0xFFF stores wdata[23:16] as red, [15:8] as green and [7:0] as blue in lookup entry addr[10:3]. `lut_rgb` presents that entry as {red, green, blue} for `lut_idx`. Host reads of this window are undefined accesses (R9).
- R2: The cursor colour table has three entries, selected by addresses 0x508, 0x510 and 0x518 (entry = addr[4:3]-1). Each entry is written and read back in the same packed RGB layout, in bits 23:0 with bits 31:24 read as zero.
- R3: The cursor bitmap occupies 0x1000..0x1FFF. Word addr[11:3] stores wdata[15:0], and a read returns that word zero-extended to 32 bits.
- R4: A write of v to 0x118 sets `width_px` to v*4, truncated to 16 bits. A read of 0x118 returns `width_px`/4.
- R5: A write of v to 0x150 sets `height_ln` to v/2, taken from v[16:1]. A read of 0x150 returns `height_ln`*2, so an odd written value reads back one lower.
- R6: The control word at 0x300 reads back in full. Its bits 22:20 select `depth` from the codes 0..7, mapped in order to 1, 2, 4, 8, 15, 16, 0, 0. Bit 10 drives `blank` and bit 23 drives `cursor_off`.
- R7: Writes to 0x400 set `top_addr` from wdata[23:0]. Writes to 0x638 set `cur_x` from wdata[23:12] and `cur_y` from wdata[11:0]. Neither register is readable.
- R8: Writes to 0x000, 0x200, 0x158..0x170 and 0x108..0x148 (8-byte aligned, excluding 0x118) are accepted with no error strobe and change no state.
- R9: Reads of any address not readable under R2..R6, and writes to any address not named in R1..R8 or R10, raise `err_pulse` for one cycle, one cycle after acceptance. Such reads return zero and such writes change nothing.
- R10: A write to 0x100000 clears both colour tables, the cursor bitmap, the control, base, cursor location and size registers, and `irq`.
- R11: `irq` rises after a cycle with `frame_done` high and falls after any accepted write. When both happen in the same cycle, `irq` is set, except that a reset write (R10) always clears it. After reset `irq` is low.
- R12: Read data and `rsp_valid` appear for one cycle, exactly one cycle after a read is accepted. Writes produce no response. `req_ready` is low while a read response is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| err_pulse | output | 1 | One-cycle strobe for an undefined access |
| frame_done | input | 1 | Frame refresh completed pulse |
| irq | output | 1 | Frame interrupt line |
| lut_idx | input | 8 | Colour lookup index from scanout |
| lut_rgb | output | 24 | Colour lookup result {r,g,b} |
| depth | output | 5 | Decoded bits per pixel |
| blank | output | 1 | Forced blanking |
| cursor_off | output | 1 | Cursor disabled |
| width_px | output | 16 | Width in pixels |
| height_ln | output | 16 | Height in lines |
| top_addr | output | 24 | Screen base offset |
| cur_x | output | 12 | Cursor column |
| cur_y | output | 12 | Cursor row |

## Verification
The interrupt line has two drivers that can meet in one cycle: a frame-done pulse that sets it and a host write that clears it. The bench drives `frame_done` in the same cycle as accepted requests, both in directed cases and in about one random access in eight. It checks `irq` after each access against a bench model in which the frame event wins over an ordinary write and loses to a reset write. A reset write issued together with `frame_done` is the directed corner that settles the three-way priority.

// File: rtl/fb_ctrl_regs.sv
module fb_ctrl_regs #(
  parameter int ADDR_W = 21,
  parameter int DIM_W  = 16,
  parameter int TOP_W  = 24,
  parameter int POS_W  = 24,
  parameter int PAL_N  = 256,
  parameter int PAT_N  = 512,
  parameter int CPAL_N = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic                     err_pulse,
  input  logic                     frame_done,
  output logic                     irq,
  input  logic [$clog2(PAL_N)-1:0] lut_idx,
  output logic [23:0]              lut_rgb,
  output logic [4:0]               depth,
  output logic                     blank,
  output logic                     cursor_off,
  output logic [DIM_W-1:0]         width_px,
  output logic [DIM_W-1:0]         height_ln,
  output logic [TOP_W-1:0]         top_addr,
  output logic [POS_W/2-1:0]       cur_x,
  output logic [POS_W/2-1:0]       cur_y
);
  localparam int PAL_AW = $clog2(PAL_N);
  localparam int PAT_AW = $clog2(PAT_N);
  localparam int HPOS   = POS_W / 2;
  localparam logic [ADDR_W-1:0] A_PAL   = ADDR_W'('h800);
  localparam logic [ADDR_W-1:0] A_PAT   = ADDR_W'('h1000);
  localparam logic [ADDR_W-1:0] A_CPAL  = ADDR_W'('h508);
  localparam logic [ADDR_W-1:0] A_HSIZE = ADDR_W'('h118);
  localparam logic [ADDR_W-1:0] A_VSIZE = ADDR_W'('h150);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h300);
  localparam logic [ADDR_W-1:0] A_TOP   = ADDR_W'('h400);
  localparam logic [ADDR_W-1:0] A_CPOS  = ADDR_W'('h638);
  localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'('h100000);

  logic [23:0]       pal   [PAL_N];
  logic [23:0]       cpal  [CPAL_N];
  logic [15:0]       pat   [PAT_N];
  logic [31:0]       ctrl;
  logic [POS_W-1:0]  cpos;
  logic [31:0]       rd_next;
  logic [1:0]        ci;

  wire [ADDR_W-1:0] a = req_addr;
  wire acc    = req_valid & req_ready;
  wire wr     = acc & req_write;
  wire in_pal = (a >= A_PAL) && (a < A_PAT);
  wire in_pat = (a >= A_PAT) && (a < ADDR_W'('h2000));
  wire in_cp  = (a >= A_CPAL) && (a < ADDR_W'('h520));
  wire hit_h  = (a == A_HSIZE);
  wire hit_v  = (a == A_VSIZE);
  wire hit_c  = (a == A_CTRL);
  wire hit_t  = (a == A_TOP);
  wire hit_p  = (a == A_CPOS);
  wire hit_r  = (a == A_SRST);
  wire ign    = (a == '0) || (a == ADDR_W'('h200)) ||
                ((a >= ADDR_W'('h108)) && (a <= ADDR_W'('h148)) && (a[2:0] == 3'd0) && !hit_h) ||
                ((a >= ADDR_W'('h158)) && (a <= ADDR_W'('h170)) && (a[2:0] == 3'd0));
  wire wr_ok  = in_pal | in_pat | in_cp | hit_h | hit_v | hit_c | hit_t | hit_p | hit_r | ign;
  wire rd_ok  = in_pat | in_cp | hit_h | hit_v | hit_c;
  wire srst   = wr & hit_r;

  assign ci         = a[4:3] - 2'd1;
  assign req_ready  = ~rsp_valid;
  assign lut_rgb    = pal[lut_idx];
  assign blank      = ctrl[10];
  assign cursor_off = ctrl[23];
  assign cur_x      = cpos[POS_W-1:HPOS];
  assign cur_y      = cpos[HPOS-1:0];

  always_comb begin
    case (ctrl[22:20])
      3'd0: depth = 5'd1;
      3'd1: depth = 5'd2;
      3'd2: depth = 5'd4;
      3'd3: depth = 5'd8;
      3'd4: depth = 5'd15;
      3'd5: depth = 5'd16;
      default: depth = 5'd0;
    endcase
  end

  always_comb begin
    rd_next = '0;
    if (in_pat)     rd_next = {16'd0, pat[a[3 +: PAT_AW]]};
    else if (in_cp) rd_next = {8'd0, cpal[ci]};
    else if (hit_h) rd_next = 32'(width_px >> 2);
    else if (hit_v) rd_next = 32'({height_ln, 1'b0});
    else if (hit_c) rd_next = ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
      for (int i = 0; i < PAT_N; i++) pat[i] <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal[i] <= '0;
      ctrl <= '0; cpos <= '0; top_addr <= '0; width_px <= '0; height_ln <= '0;
    end else if (srst) begin
      for (int i = 0; i < PAL_N; i++) pal[i] <= '0;
      for (int i = 0; i < PAT_N; i++) pat[i] <= '0;
      for (int i = 0; i < CPAL_N; i++) cpal[i] <= '0;
      ctrl <= '0; cpos <= '0; top_addr <= '0; width_px <= '0; height_ln <= '0;
    end else if (wr) begin
      if (in_pal) pal[a[3 +: PAL_AW]] <= req_wdata[23:0];
      if (in_pat) pat[a[3 +: PAT_AW]] <= req_wdata[15:0];
      if (in_cp)  cpal[ci]            <= req_wdata[23:0];
      if (hit_h)  width_px  <= {req_wdata[DIM_W-3:0], 2'b00};
      if (hit_v)  height_ln <= req_wdata[DIM_W:1];
      if (hit_c)  ctrl      <= req_wdata;
      if (hit_t)  top_addr  <= req_wdata[TOP_W-1:0];
      if (hit_p)  cpos      <= req_wdata[POS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_pulse <= 1'b0;
    end else begin
      rsp_valid <= acc & ~req_write;
      if (acc & ~req_write) rsp_rdata <= rd_ok ? rd_next : 32'd0;
      err_pulse <= acc & (req_write ? ~wr_ok : ~rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq <= 1'b0;
    else if (srst)       irq <= 1'b0;
    else if (frame_done) irq <= 1'b1;
    else if (wr)         irq <= 1'b0;
  end

  a_r12_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);
  a_r12_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid);
  a_r12_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r11_frame_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !(wr && hit_r)) |=> irq);
  a_r11_write_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !frame_done) |=> !irq);
  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_r) |=> (!irq && width_px == '0 && height_ln == '0 && top_addr == '0 && depth == 5'd1));
  a_r9_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(acc));
  a_r5_height_halved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_v) |=> height_ln == $past(req_wdata[DIM_W:1]));
  a_r4_width_scaled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_h) |=> width_px[1:0] == 2'b00);
endmodule

// File: tb/tb_fb_ctrl_regs.sv
module tb_fb_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, frame_done = 0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, err_pulse, irq, blank, cursor_off;
  logic [31:0] rsp_rdata;
  logic [7:0]  lut_idx = '0;
  logic [23:0] lut_rgb, top_addr;
  logic [4:0]  depth;
  logic [15:0] width_px, height_ln;
  logic [11:0] cur_x, cur_y;

  fb_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_pulse(err_pulse),
    .frame_done(frame_done), .irq(irq), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
    .depth(depth), .blank(blank), .cursor_off(cursor_off), .width_px(width_px),
    .height_ln(height_ln), .top_addr(top_addr), .cur_x(cur_x), .cur_y(cur_y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [23:0] m_pal [256];
  logic [23:0] m_cpal [3];
  logic [15:0] m_pat [512];
  logic [15:0] m_w, m_h;
  logic [31:0] m_ctrl;
  logic [23:0] m_top, m_pos;
  logic        m_irq;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_pal(logic [20:0] a); return a >= 21'h800 && a < 21'h1000; endfunction
  function automatic bit is_pat(logic [20:0] a); return a >= 21'h1000 && a < 21'h2000; endfunction
  function automatic bit is_cp(logic [20:0] a);  return a >= 21'h508 && a < 21'h520; endfunction
  function automatic bit is_ign(logic [20:0] a);
    return a == 0 || a == 21'h200 ||
           (a >= 21'h108 && a <= 21'h148 && a[2:0] == 0 && a != 21'h118) ||
           (a >= 21'h158 && a <= 21'h170 && a[2:0] == 0);
  endfunction
  function automatic bit rd_ok(logic [20:0] a);
    return is_pat(a) || is_cp(a) || a == 21'h118 || a == 21'h150 || a == 21'h300;
  endfunction
  function automatic bit wr_ok(logic [20:0] a);
    return is_pal(a) || is_pat(a) || is_cp(a) || is_ign(a) || a == 21'h118 || a == 21'h150 ||
           a == 21'h300 || a == 21'h400 || a == 21'h638 || a == 21'h100000;
  endfunction
  function automatic logic [4:0] exp_depth(logic [2:0] c);
    case (c) 0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 15; 5: return 16; default: return 0; endcase
  endfunction
  function automatic logic [31:0] exp_rd(logic [20:0] a);
    if (is_pat(a)) return {16'd0, m_pat[a[11:3]]};
    if (is_cp(a))  return {8'd0, m_cpal[a[4:3] - 2'd1]};
    if (a == 21'h118) return {18'd0, m_w[15:2]};
    if (a == 21'h150) return {15'd0, m_h, 1'b0};
    if (a == 21'h300) return m_ctrl;
    return 0;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 256; i++) m_pal[i] = 0;
    for (int i = 0; i < 512; i++) m_pat[i] = 0;
    for (int i = 0; i < 3; i++) m_cpal[i] = 0;
    m_w = 0; m_h = 0; m_ctrl = 0; m_top = 0; m_pos = 0; m_irq = 0;
  endtask

  task automatic model_wr(logic [20:0] a, logic [31:0] d);
    if (is_pal(a)) m_pal[a[10:3]] = d[23:0];
    if (is_pat(a)) m_pat[a[11:3]] = d[15:0];
    if (is_cp(a))  m_cpal[a[4:3] - 2'd1] = d[23:0];
    if (a == 21'h118) m_w = {d[13:0], 2'b00};
    if (a == 21'h150) m_h = d[16:1];
    if (a == 21'h300) m_ctrl = d;
    if (a == 21'h400) m_top = d[23:0];
    if (a == 21'h638) m_pos = d[23:0];
    if (a == 21'h100000) model_clear();
  endtask

  task automatic check_state();
    chk("R4 width_px", width_px, m_w);
    chk("R5 height_ln", height_ln, m_h);
    chk("R6 depth", depth, exp_depth(m_ctrl[22:20]));
    chk("R6 blank", blank, m_ctrl[10]);
    chk("R6 cursor_off", cursor_off, m_ctrl[23]);
    chk("R7 top_addr", top_addr, m_top);
    chk("R7 cur_x", cur_x, m_pos[23:12]);
    chk("R7 cur_y", cur_y, m_pos[11:0]);
    chk("R11 irq", irq, m_irq);
  endtask

  task automatic chk_lut(logic [7:0] i);
    lut_idx = i;
    #1;
    chk("R1 lut_rgb", lut_rgb, m_pal[i]);
  endtask

  task automatic op(input bit w, input logic [20:0] a, input logic [31:0] d, input bit fd, input string tag);
    logic [31:0] rd; logic rv, e, rdy;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; frame_done = fd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; frame_done = 0;
    rd = rsp_rdata; rv = rsp_valid; e = err_pulse; rdy = req_ready;
    if (w) begin
      model_wr(a, d);
      if (a == 21'h100000) m_irq = 0; else m_irq = fd;
      chk("R9 write err_pulse", e, !wr_ok(a));
      chk("R12 no write response", rv, 0);
    end else begin
      if (fd) m_irq = 1;
      chk("R12 rsp_valid", rv, 1);
      chk("R12 ready low", rdy, 0);
      chk({tag, " rdata"}, rd, exp_rd(a));
      chk("R9 read err_pulse", e, !rd_ok(a));
    end
    check_state();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    model_clear();
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state();
    chk("R12 ready after reset", req_ready, 1);
    chk("R11 irq after reset", irq, 0);
    chk_lut(8'd0);

    // R1 palette corners and unreadable window
    op(1, 21'h800, 32'hFF_A1B2C3, 0, "R1");
    op(1, 21'hFF8, 32'h00_0102FE, 0, "R1");
    chk_lut(8'd0); chk_lut(8'd255);
    op(0, 21'h800, 0, 0, "R1 palette read");
    // R2 cursor palette
    op(1, 21'h508, 32'h12_111111, 0, "R2");
    op(1, 21'h510, 32'h00_222222, 0, "R2");
    op(1, 21'h518, 32'hEE_333333, 0, "R2");
    op(0, 21'h508, 0, 0, "R2"); op(0, 21'h510, 0, 0, "R2"); op(0, 21'h518, 0, 0, "R2");
    op(0, 21'h520, 0, 0, "R9 past cursor palette");
    // R3 cursor bitmap ends
    op(1, 21'h1000, 32'hABCD1234, 0, "R3"); op(1, 21'h1FF8, 32'h5555BEEF, 0, "R3");
    op(0, 21'h1000, 0, 0, "R3"); op(0, 21'h1FF8, 0, 0, "R3");
    // R4 and R5 scaling
    op(1, 21'h118, 32'd5, 0, "R4"); op(0, 21'h118, 0, 0, "R4");
    op(1, 21'h150, 32'd7, 0, "R5"); op(0, 21'h150, 0, 0, "R5");
    // R6 every depth code plus flags
    for (int c = 0; c < 8; c++) op(1, 21'h300, (32'(c) << 20) | (c[0] ? 32'h400 : 0) | (c[1] ? 32'h800000 : 0), 0, "R6");
    op(0, 21'h300, 0, 0, "R6");
    // R7
    op(1, 21'h400, 32'h00ABCDEF, 0, "R7"); op(1, 21'h638, 32'h00123456, 0, "R7");
    op(0, 21'h400, 0, 0, "R7 unreadable"); op(0, 21'h638, 0, 0, "R7 unreadable");
    // R8 ignored writes, R9 undefined
    op(1, 21'h000, 32'hFFFFFFFF, 0, "R8"); op(1, 21'h148, 32'hFFFFFFFF, 0, "R8");
    op(1, 21'h170, 32'hFFFFFFFF, 0, "R8"); op(1, 21'h200, 32'hFFFFFFFF, 0, "R8");
    op(0, 21'h108, 0, 0, "R9 timing read");
    op(1, 21'h104, 32'hFFFFFFFF, 0, "R9"); op(1, 21'h2000, 32'hFFFFFFFF, 0, "R9");
    // R11 priority corners
    op(0, 21'h300, 0, 1, "R11 frame on read");
    op(1, 21'h000, 0, 1, "R11 frame with write");
    op(1, 21'h000, 0, 0, "R11 write lowers");
    op(0, 21'h300, 0, 1, "R11 raise again");
    // R10 soft reset together with frame pulse
    op(1, 21'h100000, 0, 1, "R10");
    chk_lut(8'd0); chk_lut(8'd255);
    op(0, 21'h1000, 0, 0, "R10 bitmap cleared"); op(0, 21'h518, 0, 0, "R10 cursor palette cleared");

    for (int n = 0; n < 600; n++) begin
      logic [20:0] a; bit w, fd; logic [31:0] d;
      w = $urandom_range(0, 1); d = $urandom; fd = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 10))
        0, 1: a = 21'h800 + 21'($urandom_range(0, 255) << 3);
        2:    a = 21'h1000 + 21'($urandom_range(0, 511) << 3);
        3:    a = 21'h508 + 21'($urandom_range(0, 2) << 3);
        4:    a = 21'h118;
        5:    a = 21'h150;
        6:    a = 21'h300;
        7:    a = ($urandom_range(0, 1) != 0) ? 21'h400 : 21'h638;
        8:    a = 21'h158 + 21'($urandom_range(0, 3) << 3);
        9:    case ($urandom_range(0, 3)) 0: a = 21'h104; 1: a = 21'h700; 2: a = 21'h100008; default: a = 21'h3000; endcase
        default: a = (n % 97 == 0) ? 21'h100000 : 21'h300;
      endcase
      op(w, a, d, fd, "R1 R2 R3 R4 R5 R6 random");
      chk_lut(8'($urandom_range(0, 255)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule